// File: doc/BRIEF.md
# Two-Rank Transmit Word Holding Stage

This block sits between a 16-bit parallel data bus and the shift path of a serial word encoder. It holds each outgoing word in two register ranks in series. The first rank follows the bus or holds a captured word. The second rank follows the first rank, or freezes while a word is being shifted out. Because the second rank is frozen during a transmission, the next word can be put into the first rank before the current word has left.

Each byte lane of both ranks has its own enable, so a byte-wide subsystem can write the word one byte at a time. In byte mode the lower byte of the bus feeds both lanes. A single-bit serial source can also be passed through: the upper lane is left following the bus and unfrozen, and the top bus bit then goes straight to the serial output. All state is in clocked registers with a synchronous active-high reset.

Top module: `txh_word_stage`

## Requirements
- R1: While `rst` is high at a clock edge, both ranks are cleared, so `stage1_q`, `stage2_q` and `serial_q` read zero after that edge.
- R2: In word mode (`byte_mode`=0), a lane whose `latch_en` bit is 1 at an edge loads its first rank from its own bus byte (lane 0 from bits 7:0, lane 1 from bits 15:8).
- R3: A lane whose `latch_en` bit is 0 at an edge keeps its first-rank value, whatever the bus does.
- R4: A lane whose `load_en` bit is 1 at an edge keeps its second-rank value, even when its first rank changes.
- R5: A lane whose `load_en` bit is 0 at an edge copies into its second rank the first-rank value that was present just before that edge.
- R6: The enables of one lane have no effect on the other lane's first or second rank.
- R7: In byte mode (`byte_mode`=1), both lanes load from bus bits 7:0, and bus bits 15:8 have no effect.
- R8: A new word latched into the first rank while `load_en` is 1 leaves `stage2_q` unchanged, and it appears on `stage2_q` one edge after `load_en` returns to 0.
- R9: `serial_q` is the top bit of the second rank. With `latch_en[1]`=1 and `load_en[1]`=0 in word mode, bus bit 15 reaches `serial_q` two edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears both ranks |
| byte_mode | input | 1 | 1: lower bus byte feeds every lane; 0: each lane has its own byte |
| bus_in | input | 16 | Parallel data bus |
| latch_en | input | 2 | Per-lane first-rank enable, 1 = follow bus, 0 = hold |
| load_en | input | 2 | Per-lane second-rank freeze, 1 = hold (tied to send-data), 0 = follow first rank |
| stage1_q | output | 16 | First-rank contents |
| stage2_q | output | 16 | Second-rank contents, the word handed to the shifter |
| serial_q | output | 1 | Top bit of the second rank, the serial pass-through output |

## Verification
The properties assume that every input is a known 0 or 1 at each rising edge and that `byte_mode` describes how the bus is wired, so the lane-source rules can be stated from the bus ports alone. The stimulus changes inputs only on falling edges. It drives both enable bits and the mode from tasks, so they are never X after reset, and it changes `byte_mode` only between phases. The checks cover the cases where a freeze and a new first-rank capture fall on the same edge, since that is where a transmission and the next-word latch overlap.

// File: rtl/txh_pkg.sv
package txh_pkg;
  localparam int unsigned LANE_W_DEF = 8;
  localparam int unsigned LANES_DEF  = 2;

  typedef enum logic {
    BUSMODE_WORD = 1'b0,
    BUSMODE_BYTE = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/txh_lane_route.sv
module txh_lane_route #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned BUS_W = LANE_W * LANES
) (
  input  logic                         byte_mode,
  input  logic [BUS_W-1:0]             bus_in,
  output logic [LANES-1:0][LANE_W-1:0] lane_d
);
  import txh_pkg::*;

  bus_mode_e mode;
  assign mode = bus_mode_e'(byte_mode);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_base
      assign lane_d[g] = bus_in[LANE_W-1:0];
    end else begin : g_upper
      always_comb begin
        if (mode == BUSMODE_BYTE) lane_d[g] = bus_in[LANE_W-1:0];
        else                      lane_d[g] = bus_in[g*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/txh_rank1.sv
module txh_rank1 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         follow,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (follow) q <= d;
  end
endmodule

// File: rtl/txh_rank2.sv
module txh_rank2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         freeze,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (!freeze) q <= d;
  end
endmodule

// File: rtl/txh_word_stage.sv
module txh_word_stage #(
  parameter int unsigned LANE_W = txh_pkg::LANE_W_DEF,
  parameter int unsigned LANES  = txh_pkg::LANES_DEF,
  localparam int unsigned BUS_W = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_mode,
  input  logic [BUS_W-1:0] bus_in,
  input  logic [LANES-1:0] latch_en,
  input  logic [LANES-1:0] load_en,
  output logic [BUS_W-1:0] stage1_q,
  output logic [BUS_W-1:0] stage2_q,
  output logic             serial_q
);
  logic [LANES-1:0][LANE_W-1:0] lane_d;
  logic [LANES-1:0][LANE_W-1:0] r1_q;
  logic [LANES-1:0][LANE_W-1:0] r2_q;

  txh_lane_route #(.LANE_W(LANE_W), .LANES(LANES)) u_route (
    .byte_mode (byte_mode),
    .bus_in    (bus_in),
    .lane_d    (lane_d)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    txh_rank1 #(.W(LANE_W)) u_r1 (
      .clk    (clk),
      .rst    (rst),
      .follow (latch_en[g]),
      .d      (lane_d[g]),
      .q      (r1_q[g])
    );
    txh_rank2 #(.W(LANE_W)) u_r2 (
      .clk    (clk),
      .rst    (rst),
      .freeze (load_en[g]),
      .d      (r1_q[g]),
      .q      (r2_q[g])
    );
    assign stage1_q[g*LANE_W +: LANE_W] = r1_q[g];
    assign stage2_q[g*LANE_W +: LANE_W] = r2_q[g];
  end

  assign serial_q = r2_q[LANES-1][LANE_W-1];
endmodule

// File: rtl/txh_word_stage_chk.sv
module txh_word_stage_chk #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned BUS_W = LANE_W * LANES
) (
  input logic             clk,
  input logic             rst,
  input logic             byte_mode,
  input logic [BUS_W-1:0] bus_in,
  input logic [LANES-1:0] latch_en,
  input logic [LANES-1:0] load_en,
  input logic [BUS_W-1:0] stage1_q,
  input logic [BUS_W-1:0] stage2_q,
  input logic             serial_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (stage1_q == '0 && stage2_q == '0 && !serial_q)); // R1

  AST_LANE0_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    latch_en[0] |=> stage1_q[LANE_W-1:0] == $past(bus_in[LANE_W-1:0])); // R2

  AST_TOP_WORDMODE: assert property (@(posedge clk) disable iff (rst)
    (latch_en[LANES-1] && !byte_mode) |=>
      stage1_q[BUS_W-1 -: LANE_W] == $past(bus_in[BUS_W-1 -: LANE_W])); // R2

  AST_TOP_BYTEMODE: assert property (@(posedge clk) disable iff (rst)
    (latch_en[LANES-1] && byte_mode) |=>
      stage1_q[BUS_W-1 -: LANE_W] == $past(bus_in[LANE_W-1:0])); // R7

  AST_LANE0_HOLD: assert property (@(posedge clk) disable iff (rst)
    !latch_en[0] |=> $stable(stage1_q[LANE_W-1:0])); // R3

  AST_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !latch_en[LANES-1] |=> $stable(stage1_q[BUS_W-1 -: LANE_W])); // R3

  AST_LANE0_FREEZE: assert property (@(posedge clk) disable iff (rst)
    load_en[0] |=> $stable(stage2_q[LANE_W-1:0])); // R4

  AST_TOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    load_en[LANES-1] |=> $stable(stage2_q[BUS_W-1 -: LANE_W])); // R4

  AST_LANE0_PASS: assert property (@(posedge clk) disable iff (rst)
    !load_en[0] |=> stage2_q[LANE_W-1:0] == $past(stage1_q[LANE_W-1:0])); // R5

  AST_TOP_PASS: assert property (@(posedge clk) disable iff (rst)
    !load_en[LANES-1] |=> stage2_q[BUS_W-1 -: LANE_W] == $past(stage1_q[BUS_W-1 -: LANE_W])); // R5

  AST_SERIAL_PATH: assert property (@(posedge clk) disable iff (rst)
    !load_en[LANES-1] |=> serial_q == $past(stage1_q[BUS_W-1])); // R9
endmodule

bind txh_word_stage txh_word_stage_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .byte_mode (byte_mode),
  .bus_in    (bus_in),
  .latch_en  (latch_en),
  .load_en   (load_en),
  .stage1_q  (stage1_q),
  .stage2_q  (stage2_q),
  .serial_q  (serial_q)
);

// File: tb/sim_txh_word_stage.sv
module sim_txh_word_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_mode = 1'b0;
  logic [15:0] bus_in = '0;
  logic [1:0]  latch_en = '0;
  logic [1:0]  load_en = '0;
  logic [15:0] stage1_q, stage2_q;
  logic        serial_q;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit    done = 1'b0;

  logic [15:0] m1 = '0;
  logic [15:0] m2 = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  txh_word_stage u0 (
    .clk(clk), .rst(rst), .byte_mode(byte_mode), .bus_in(bus_in),
    .latch_en(latch_en), .load_en(load_en),
    .stage1_q(stage1_q), .stage2_q(stage2_q), .serial_q(serial_q)
  );

  // Reference model: behavioural, per-byte masks on integers
  always @(posedge clk) begin
    int src_hi;
    int n1;
    int n2;
    if (rst) begin
      m1 = '0; m2 = '0;
    end else begin
      src_hi = byte_mode ? int'(bus_in[7:0]) : int'(bus_in[15:8]);
      n1 = int'(m1);
      n2 = int'(m2);
      if (!load_en[0]) n2 = (n2 & 32'hFF00) | (int'(m1) & 32'h00FF);
      if (!load_en[1]) n2 = (n2 & 32'h00FF) | (int'(m1) & 32'hFF00);
      if (latch_en[0]) n1 = (n1 & 32'hFF00) | int'(bus_in[7:0]);
      if (latch_en[1]) n1 = (n1 & 32'h00FF) | (src_hi << 8);
      m1 = n1[15:0];
      m2 = n2[15:0];
    end
  end

  task automatic check(input string t, input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", t, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(tag, stage1_q, m1, "stage1_q");
      check(tag, stage2_q, m2, "stage2_q");
      check("R9", {15'd0, serial_q}, {15'd0, m2[15]}, "serial_q");
    end
  end

  task automatic step(input logic [15:0] b, input logic [1:0] la, input logic [1:0] lo);
    @(negedge clk);
    #1;
    bus_in = b; latch_en = la; load_en = lo;
  endtask

  function automatic logic [15:0] nextw(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin : watchdog
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    check("R1", stage2_q, 16'h0000, "reset stage2");
    check("R1", stage1_q, 16'h0000, "reset stage1");
    #1; rst = 1'b0;

    // R2 / R5: both ranks follow
    tag = "R5";
    for (int i = 0; i < 20; i++) begin
      lfsr = nextw(lfsr);
      step(lfsr, 2'b11, 2'b00);
    end
    step(16'h1234, 2'b11, 2'b00);
    step(16'h0000, 2'b00, 2'b00);
    @(negedge clk);
    check("R2", stage1_q, 16'h1234, "word latched");
    check("R5", stage2_q, 16'h1234, "word passed");

    // R3: first rank held, bus toggles
    tag = "R3";
    for (int i = 0; i < 10; i++) begin
      lfsr = nextw(lfsr);
      step(lfsr, 2'b00, 2'b00);
    end
    @(negedge clk);
    check("R3", stage1_q, 16'h1234, "held word");

    // R4 / R8: freeze, latch next word mid-transmission
    tag = "R4";
    step(16'hBEEF, 2'b11, 2'b11);
    step(16'hBEEF, 2'b00, 2'b11);
    for (int i = 0; i < 6; i++) step(16'h5555, 2'b00, 2'b11);
    @(negedge clk);
    check("R8", stage2_q, 16'h1234, "frozen during send");
    check("R8", stage1_q, 16'hBEEF, "next word held");
    tag = "R8";
    step(16'h5555, 2'b00, 2'b00);
    @(negedge clk);
    check("R8", stage2_q, 16'hBEEF, "next word after release");

    // R6: lane independence
    tag = "R6";
    step(16'hA1B2, 2'b01, 2'b10);
    step(16'hC3D4, 2'b10, 2'b01);
    step(16'h0000, 2'b00, 2'b00);
    @(negedge clk);
    check("R6", stage1_q, 16'hC3B2, "per-lane latch");
    for (int i = 0; i < 12; i++) begin
      lfsr = nextw(lfsr);
      step(lfsr, lfsr[1:0], lfsr[3:2]);
    end

    // R7: byte mode, lower byte feeds both lanes
    tag = "R7";
    byte_mode = 1'b1;
    step(16'hFF3C, 2'b01, 2'b11);
    step(16'h0096, 2'b10, 2'b11);
    step(16'hEE00, 2'b00, 2'b00);
    @(negedge clk);
    check("R7", stage1_q, 16'h963C, "bytes assembled");
    for (int i = 0; i < 12; i++) begin
      lfsr = nextw(lfsr);
      step(lfsr, lfsr[5:4], lfsr[7:6]);
    end
    byte_mode = 1'b0;

    // R9: serial pass-through on bit 15
    tag = "R9";
    step(16'h0000, 2'b10, 2'b01);
    step(16'h8000, 2'b10, 2'b01);
    step(16'h0000, 2'b10, 2'b01);
    @(negedge clk);
    check("R9", {15'd0, serial_q}, 16'h0001, "bit 15 two edges later");
    for (int i = 0; i < 16; i++) begin
      lfsr = nextw(lfsr);
      step(lfsr, 2'b10, 2'b01);
    end

    // R1: reset mid-run
    tag = "R1";
    step(16'hFFFF, 2'b11, 2'b00);
    #1; rst = 1'b1;
    @(negedge clk);
    check("R1", stage2_q, 16'h0000, "reset clears stage2");
    check("R1", stage1_q, 16'h0000, "reset clears stage1");
    #1; rst = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule